// File: doc/BRIEF.md
# Two-Phase Signature Prefilter

This block screens a byte stream for places where a malware signature might begin, so that only a small share of positions is passed on to a slower exact matcher. It holds a sliding window of `WORD_W/8` bytes over the stream. At each window position it makes two lookups into a set of `NUM_BANKS` ternary match banks, and all banks are searched together. The first lookup is the skip plane. A hit there that carries a nonzero skip count moves the window forward by that count straight away. When the skip plane misses, or the winning entry's count is zero, the second lookup is the confirm plane. A miss there advances the window by one byte. A hit there offers a candidate (position and signature index) on a valid/ready output, and scanning waits until that candidate is taken.

Each table entry carries its own plane bit, so the split between skip entries and confirm entries can be redrawn at any time by rewriting entries. Skip entries compare only the low `NO_W` bits of the window, which are the bytes after the current one. Confirm entries always compare the top `BIN_W` bits, which hold the current byte, exactly. Their remaining bits are compared ternary.

The controller is a five-state machine. FILL takes bytes until the window is full or the stream has ended. It goes to SKIPCHK when a position can be evaluated, and to DONE when nothing is left. SKIPCHK goes back to FILL on a skip, and otherwise goes to CONFIRM. CONFIRM goes to OFFER on a hit, and back to FILL after a one-byte step on a miss. OFFER goes back to FILL after a one-byte step once the candidate is accepted. DONE holds until reset.

Top module: `sig_prefilter`

## Requirements
- R1: When the skip plane hits with a nonzero skip count S at position p, the next evaluated position is p+S, and no candidate is offered for position p.
- R2: When the skip plane misses, or the winning skip entry has count 0, the confirm plane is consulted at the same position.
- R3: When the confirm plane misses at position p, the next evaluated position is p+1, and no candidate is offered for p.
- R4: When the confirm plane hits at position p, a candidate is offered with `cand_pos` = p and `cand_idx` = bank*ENTRIES + entry (bank in the upper bits). After it is accepted, the next evaluated position is p+1.
- R5: While `cand_valid` is high and `cand_ready` is low, `cand_valid`, `cand_pos` and `cand_idx` hold their values, and `in_ready` is low.
- R6: The byte at position p occupies window bits [WORD_W-1:WORD_W-8], and later bytes follow toward the LSB. A skip entry compares only window bits [NO_W-1:0]; care bits above that are ignored.
- R7: A confirm entry always compares window bits [WORD_W-1:WORD_W-BIN_W] against its value, whatever its care mask says there. Its other bits are compared where care is 1.
- R8: Entry plane bit `tbl_plane` = 1 makes the entry a skip entry, and 0 makes it a confirm entry. An entry takes part only in its own plane, and a rewrite moves it between planes.
- R9: All banks are searched at once and a hit in any bank counts. The lowest-numbered bank with a hit supplies the skip count or the index. Within a bank, the lowest-numbered entry wins.
- R10: After the byte marked `in_last`, window bytes past the end read as 0. Positions are evaluated up to the last byte, and a skip past the end stops the scan. `done` then rises and stays high, with `in_ready` and `cand_valid` low.
- R11: After reset, `in_ready` = 1, `cand_valid` = 0, `done` = 0, and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of the stream |
| in_ready | output | 1 | Engine takes the byte this cycle |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_bank | input | clog2(NUM_BANKS) | Bank to write |
| tbl_entry | input | clog2(BANK_ENTRIES) | Entry to write |
| tbl_valid | input | 1 | Entry valid bit |
| tbl_plane | input | 1 | 1 = skip plane, 0 = confirm plane |
| tbl_value | input | WORD_W | Entry compare value |
| tbl_care | input | WORD_W | Entry care mask (1 = compare) |
| tbl_shift | input | SHIFT_W | Skip count for skip entries |
| cand_valid | output | 1 | Candidate offered |
| cand_ready | input | 1 | Downstream accepts the candidate |
| cand_pos | output | POS_W | Stream position of the candidate |
| cand_idx | output | clog2(NUM_BANKS)+clog2(BANK_ENTRIES) | Signature index {bank, entry} |
| done | output | 1 | Stream fully scanned |

## Verification
The bench builds the default configuration: four banks of four entries, a 32-bit window and a 2-bit skip count. At that size a mixed table can put skip entries with counts 0, 1 and 3 and overlapping confirm entries side by side in different banks. Every 8-byte stream over a two-symbol alphabet (256 streams) is then swept against an arithmetic model of the two-phase scan. This covers every skip/confirm interleaving, skips that run past the end of the stream, and zero-padded tail windows. Directed cases add bank and entry priority, care-mask forcing, moving an entry between planes, one-byte streams, and candidate backpressure.

// File: rtl/pf_pkg.sv
package pf_pkg;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_SKIPCHK,
        ST_CONFIRM,
        ST_OFFER,
        ST_DONE
    } scan_state_e;

    localparam logic PLANE_CONFIRM = 1'b0;
    localparam logic PLANE_SKIP    = 1'b1;

endpackage

// File: rtl/pf_match_bank.sv
module pf_match_bank
    import pf_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int WORD_W  = 32,
    parameter int NO_W    = 24,
    parameter int BIN_W   = 8,
    parameter int SHIFT_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_entry,
    input  logic                       wr_valid,
    input  logic                       wr_plane,
    input  logic [WORD_W-1:0]          wr_value,
    input  logic [WORD_W-1:0]          wr_care,
    input  logic [SHIFT_W-1:0]         wr_shift,
    input  logic [WORD_W-1:0]          window,
    output logic                       skip_hit,
    output logic [SHIFT_W-1:0]         skip_count,
    output logic                       conf_hit,
    output logic [$clog2(ENTRIES)-1:0] conf_entry
);

    localparam int EIDX_W = $clog2(ENTRIES);
    localparam logic [WORD_W-1:0] SKIP_MASK = {{(WORD_W-NO_W){1'b0}}, {NO_W{1'b1}}};
    localparam logic [WORD_W-1:0] BIN_MASK  = {{BIN_W{1'b1}}, {(WORD_W-BIN_W){1'b0}}};

    logic [ENTRIES-1:0] ent_valid;
    logic [ENTRIES-1:0] ent_plane;
    logic [WORD_W-1:0]  ent_value [ENTRIES];
    logic [WORD_W-1:0]  ent_care  [ENTRIES];
    logic [SHIFT_W-1:0] ent_shift [ENTRIES];
    logic [ENTRIES-1:0] skip_vec;
    logic [ENTRIES-1:0] conf_vec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
        end else if (wr_en) begin
            ent_valid[wr_entry] <= wr_valid;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_plane[wr_entry] <= wr_plane;
            ent_value[wr_entry] <= wr_value;
            ent_care[wr_entry]  <= wr_care;
            ent_shift[wr_entry] <= wr_shift;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign skip_vec[g] = ent_valid[g] && (ent_plane[g] == PLANE_SKIP) &&
                             (((window ^ ent_value[g]) & ent_care[g] & SKIP_MASK) == '0);
        assign conf_vec[g] = ent_valid[g] && (ent_plane[g] == PLANE_CONFIRM) &&
                             (((window ^ ent_value[g]) & (ent_care[g] | BIN_MASK)) == '0);
    end

    always_comb begin
        skip_hit   = |skip_vec;
        conf_hit   = |conf_vec;
        skip_count = '0;
        conf_entry = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (skip_vec[i]) skip_count = ent_shift[i];
            if (conf_vec[i]) conf_entry = EIDX_W'(i);
        end
    end

    // R9: the reported entry hits and no lower entry hits
    p_low_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        conf_hit |-> (conf_vec[conf_entry] &&
                      ((conf_vec & ~({ENTRIES{1'b1}} << conf_entry)) == '0)));

    // R8: a write sets the valid bit of the addressed entry
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ent_valid[$past(wr_entry)] == $past(wr_valid)));

endmodule

// File: rtl/pf_window.sv
module pf_window #(
    parameter int WORD_W = 32,
    parameter int POS_W  = 16,
    parameter int ADV_W  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load_en,
    input  logic [7:0]                   load_byte,
    input  logic                         load_last,
    input  logic                         adv_en,
    input  logic [ADV_W-1:0]             adv_by,
    output logic [WORD_W-1:0]            window,
    output logic [$clog2(WORD_W/8+1)-1:0] fill,
    output logic                         ended,
    output logic [POS_W-1:0]             pos
);

    localparam int WIN_BYTES = WORD_W / 8;
    localparam int CNT_W     = $clog2(WIN_BYTES + 1);

    logic [WORD_W-1:0] load_word;
    logic [CNT_W-1:0]  adv_ext;

    assign load_word = window | ({load_byte, {(WORD_W-8){1'b0}}} >> (8 * fill));
    assign adv_ext   = CNT_W'(adv_by);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window <= '0;
            fill   <= '0;
            ended  <= 1'b0;
            pos    <= '0;
        end else if (load_en) begin
            window <= load_word;
            fill   <= fill + 1'b1;
            ended  <= load_last;
        end else if (adv_en) begin
            window <= window << (8 * adv_by);
            fill   <= (fill > adv_ext) ? (fill - adv_ext) : '0;
            pos    <= pos + POS_W'(adv_by);
        end
    end

    // R10: occupancy never exceeds the window
    p_fill_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(WIN_BYTES));

    // R10: bytes beyond the occupied part read as zero
    p_pad_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (window << (8 * fill)) == '0);

    // R10: end of stream, once seen, is kept
    p_ended_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ended |=> ended);

endmodule

// File: rtl/sig_prefilter.sv
module sig_prefilter
    import pf_pkg::*;
#(
    parameter int NUM_BANKS    = 4,
    parameter int BANK_ENTRIES = 4,
    parameter int WORD_W       = 32,
    parameter int NO_W         = 24,
    parameter int BIN_W        = 8,
    parameter int SHIFT_W      = 2,
    parameter int POS_W        = 16
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          in_valid,
    input  logic [7:0]                                    in_data,
    input  logic                                          in_last,
    output logic                                          in_ready,
    input  logic                                          tbl_we,
    input  logic [$clog2(NUM_BANKS)-1:0]                  tbl_bank,
    input  logic [$clog2(BANK_ENTRIES)-1:0]               tbl_entry,
    input  logic                                          tbl_valid,
    input  logic                                          tbl_plane,
    input  logic [WORD_W-1:0]                             tbl_value,
    input  logic [WORD_W-1:0]                             tbl_care,
    input  logic [SHIFT_W-1:0]                            tbl_shift,
    output logic                                          cand_valid,
    input  logic                                          cand_ready,
    output logic [POS_W-1:0]                              cand_pos,
    output logic [$clog2(NUM_BANKS)+$clog2(BANK_ENTRIES)-1:0] cand_idx,
    output logic                                          done
);

    localparam int BANK_W    = $clog2(NUM_BANKS);
    localparam int EIDX_W    = $clog2(BANK_ENTRIES);
    localparam int IDX_W     = BANK_W + EIDX_W;
    localparam int WIN_BYTES = WORD_W / 8;
    localparam int CNT_W     = $clog2(WIN_BYTES + 1);
    localparam logic [SHIFT_W-1:0] STEP_ONE = SHIFT_W'(1);

    scan_state_e state_q, state_d;

    logic [WORD_W-1:0]  window;
    logic [CNT_W-1:0]   fill;
    logic               ended;
    logic [POS_W-1:0]   win_pos;
    logic               load_en;
    logic               adv_en;
    logic [SHIFT_W-1:0] adv_by;
    logic               cand_load;
    logic               eval_ok;

    logic [NUM_BANKS-1:0] bk_skip_hit;
    logic [NUM_BANKS-1:0] bk_conf_hit;
    logic [SHIFT_W-1:0]   bk_skip_count [NUM_BANKS];
    logic [EIDX_W-1:0]    bk_conf_entry [NUM_BANKS];

    logic               res_skip_hit;
    logic [SHIFT_W-1:0] res_skip_count;
    logic               res_conf_hit;
    logic [IDX_W-1:0]   res_conf_idx;
    logic [POS_W-1:0]   cand_pos_q;
    logic [IDX_W-1:0]   cand_idx_q;

    pf_window #(
        .WORD_W (WORD_W),
        .POS_W  (POS_W),
        .ADV_W  (SHIFT_W)
    ) window_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_byte (in_data),
        .load_last (in_last),
        .adv_en    (adv_en),
        .adv_by    (adv_by),
        .window    (window),
        .fill      (fill),
        .ended     (ended),
        .pos       (win_pos)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        pf_match_bank #(
            .ENTRIES (BANK_ENTRIES),
            .WORD_W  (WORD_W),
            .NO_W    (NO_W),
            .BIN_W   (BIN_W),
            .SHIFT_W (SHIFT_W)
        ) bank_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (tbl_we && (tbl_bank == BANK_W'(b))),
            .wr_entry   (tbl_entry),
            .wr_valid   (tbl_valid),
            .wr_plane   (tbl_plane),
            .wr_value   (tbl_value),
            .wr_care    (tbl_care),
            .wr_shift   (tbl_shift),
            .window     (window),
            .skip_hit   (bk_skip_hit[b]),
            .skip_count (bk_skip_count[b]),
            .conf_hit   (bk_conf_hit[b]),
            .conf_entry (bk_conf_entry[b])
        );
    end

    // lowest-numbered bank wins
    always_comb begin
        res_skip_hit   = |bk_skip_hit;
        res_conf_hit   = |bk_conf_hit;
        res_skip_count = '0;
        res_conf_idx   = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (bk_skip_hit[b]) res_skip_count = bk_skip_count[b];
            if (bk_conf_hit[b]) res_conf_idx   = {BANK_W'(b), bk_conf_entry[b]};
        end
    end

    assign eval_ok = (fill == CNT_W'(WIN_BYTES)) || (ended && (fill != '0));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FILL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        load_en   = 1'b0;
        adv_en    = 1'b0;
        adv_by    = '0;
        cand_load = 1'b0;
        unique case (state_q)
            ST_FILL: begin
                if (eval_ok)    state_d = ST_SKIPCHK;
                else if (ended) state_d = ST_DONE;
                else            load_en = in_valid;
            end
            ST_SKIPCHK: begin
                if (res_skip_hit && (res_skip_count != '0)) begin
                    adv_en  = 1'b1;
                    adv_by  = res_skip_count;
                    state_d = ST_FILL;
                end else begin
                    state_d = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (res_conf_hit) begin
                    cand_load = 1'b1;
                    state_d   = ST_OFFER;
                end else begin
                    adv_en  = 1'b1;
                    adv_by  = STEP_ONE;
                    state_d = ST_FILL;
                end
            end
            ST_OFFER: begin
                if (cand_ready) begin
                    adv_en  = 1'b1;
                    adv_by  = STEP_ONE;
                    state_d = ST_FILL;
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
            default: state_d = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_pos_q <= '0;
            cand_idx_q <= '0;
        end else if (cand_load) begin
            cand_pos_q <= win_pos;
            cand_idx_q <= res_conf_idx;
        end
    end

    always_comb begin
        in_ready   = (state_q == ST_FILL) && (fill != CNT_W'(WIN_BYTES)) && !ended;
        cand_valid = (state_q == ST_OFFER);
        done       = (state_q == ST_DONE);
        cand_pos   = cand_pos_q;
        cand_idx   = cand_idx_q;
    end

    // R1: a nonzero skip moves the position by the skip count
    p_skip_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIPCHK && res_skip_hit && res_skip_count != '0) |=>
        (state_q == ST_FILL && win_pos == $past(win_pos) + POS_W'($past(res_skip_count))));

    // R2: no skip means the confirm plane is consulted next
    p_fallthrough_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIPCHK && !(res_skip_hit && res_skip_count != '0)) |=>
        (state_q == ST_CONFIRM && $stable(win_pos)));

    // R3: a confirm miss steps one byte
    p_miss_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONFIRM && !res_conf_hit) |=>
        (win_pos == $past(win_pos) + POS_W'(1) && !cand_valid));

    // R4: a confirm hit offers the current position
    p_offer_pos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONFIRM && res_conf_hit) |=> (cand_valid && cand_pos == $past(win_pos)));

    // R5: an unaccepted candidate is held unchanged
    p_cand_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && !cand_ready) |=>
        (cand_valid && $stable(cand_pos) && $stable(cand_idx)));

    // R5: input is stalled while a candidate waits
    p_input_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> !in_ready);

    // R10: done is held with the interfaces quiet
    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !in_ready && !cand_valid));

endmodule

// File: tb/sig_prefilter_tb_top.sv
module sig_prefilter_tb_top;

    localparam int NB = 4;
    localparam int NE = 4;
    localparam int PW = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        tbl_we = 1'b0;
    logic [1:0]  tbl_bank = '0;
    logic [1:0]  tbl_entry = '0;
    logic        tbl_valid = 1'b0;
    logic        tbl_plane = 1'b0;
    logic [31:0] tbl_value = '0;
    logic [31:0] tbl_care = '0;
    logic [1:0]  tbl_shift = '0;
    logic        cand_valid;
    logic        cand_ready = 1'b0;
    logic [PW-1:0] cand_pos;
    logic [3:0]  cand_idx;
    logic        done;

    always #5 clk = ~clk;

    sig_prefilter #(
        .NUM_BANKS (NB), .BANK_ENTRIES (NE), .WORD_W (32), .NO_W (24),
        .BIN_W (8), .SHIFT_W (2), .POS_W (PW)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_data (in_data),
        .in_last (in_last), .in_ready (in_ready), .tbl_we (tbl_we),
        .tbl_bank (tbl_bank), .tbl_entry (tbl_entry), .tbl_valid (tbl_valid),
        .tbl_plane (tbl_plane), .tbl_value (tbl_value), .tbl_care (tbl_care),
        .tbl_shift (tbl_shift), .cand_valid (cand_valid), .cand_ready (cand_ready),
        .cand_pos (cand_pos), .cand_idx (cand_idx), .done (done)
    );

    bit        mv [NB][NE];
    bit        mp [NB][NE];
    bit [31:0] mval [NB][NE];
    bit [31:0] mcare [NB][NE];
    bit [1:0]  msh [NB][NE];
    bit [7:0]  sbuf [64];
    int        slen;
    int        exp_pos [64];
    int        exp_idx [64];
    int        exp_n;
    int        got_pos [64];
    int        got_idx [64];
    int        got_n = 0;
    int        last_base;
    int        checks = 0, errors = 0, col_checks = 0, col_errors = 0;
    bit        bp_mode = 1'b0;
    bit        prev_stall = 1'b0;
    int        prev_pos, prev_idx;
    int        cyc = 0;
    bit        finished = 1'b0;

    // candidate collector and R5 stall checks
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            prev_stall = 1'b0;
        end else begin
            cand_ready = bp_mode ? (cyc % 3 == 0) : 1'b1;
            if (prev_stall) begin
                col_checks++;
                if (!cand_valid || cand_pos != prev_pos || cand_idx != prev_idx) begin
                    col_errors++;
                    $display("FAIL R5 held candidate: actual valid=%0d pos=%0d idx=%0d expected valid=1 pos=%0d idx=%0d",
                             cand_valid, cand_pos, cand_idx, prev_pos, prev_idx);
                end
            end
            if (cand_valid) begin
                col_checks++;
                if (in_ready) begin
                    col_errors++;
                    $display("FAIL R5 in_ready during offer: actual=1 expected=0");
                end
            end
            if (cand_valid && cand_ready) begin
                got_pos[got_n % 64] = cand_pos;
                got_idx[got_n % 64] = cand_idx;
                got_n++;
            end
            prev_stall = cand_valid && !cand_ready;
            prev_pos   = cand_pos;
            prev_idx   = cand_idx;
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic clear_tables();
        for (int b = 0; b < NB; b++)
            for (int e = 0; e < NE; e++) begin
                mv[b][e] = 0; mp[b][e] = 0; mval[b][e] = 0; mcare[b][e] = 0; msh[b][e] = 0;
            end
    endtask

    task automatic put(input int b, input int e, input bit plane, input bit [31:0] val,
                       input bit [31:0] care, input bit [1:0] sh);
        mv[b][e] = 1; mp[b][e] = plane; mval[b][e] = val; mcare[b][e] = care; msh[b][e] = sh;
    endtask

    task automatic set_stream(input bit [63:0] bytes, input int n);
        slen = n;
        for (int i = 0; i < n; i++) sbuf[i] = bytes[8*(n-1-i) +: 8];
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; tbl_we = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic load_dut();
        for (int b = 0; b < NB; b++)
            for (int e = 0; e < NE; e++)
                if (mv[b][e]) begin
                    @(negedge clk);
                    tbl_we = 1'b1; tbl_bank = 2'(b); tbl_entry = 2'(e); tbl_valid = 1'b1;
                    tbl_plane = mp[b][e]; tbl_value = mval[b][e]; tbl_care = mcare[b][e];
                    tbl_shift = msh[b][e];
                end
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    function automatic bit [31:0] win_at(input int p);
        bit [31:0] w = 0;
        for (int k = 0; k < 4; k++) w = {w[23:0], ((p + k) < slen) ? sbuf[p + k] : 8'h00};
        return w;
    endfunction

    // arithmetic model of the two-phase scan
    task automatic model();
        int p = 0;
        exp_n = 0;
        while (p < slen) begin
            bit [31:0] w = win_at(p);
            bit sk = 0, cf = 0;
            int sc = 0, ci = 0;
            for (int b = 0; b < NB; b++)
                for (int e = 0; e < NE; e++) begin
                    if (!sk && mv[b][e] && mp[b][e] &&
                        (((w ^ mval[b][e]) & mcare[b][e] & 32'h00FF_FFFF) == 0)) begin
                        sk = 1; sc = msh[b][e];
                    end
                    if (!cf && mv[b][e] && !mp[b][e] &&
                        (((w ^ mval[b][e]) & (mcare[b][e] | 32'hFF00_0000)) == 0)) begin
                        cf = 1; ci = b * NE + e;
                    end
                end
            if (sk && sc != 0) begin
                p += sc;
            end else begin
                if (cf) begin
                    exp_pos[exp_n] = p; exp_idx[exp_n] = ci; exp_n++;
                end
                p += 1;
            end
        end
    endtask

    task automatic run_stream(input string req);
        int t = 0;
        int n;
        last_base = got_n;
        model();
        for (int i = 0; i < slen; i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = sbuf[i]; in_last = (i == slen - 1);
            while (!in_ready) @(negedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        while (!done && t < 3000) begin @(negedge clk); t++; end
        check_eq("R10", "done reached", int'(done), 1);
        n = got_n - last_base;
        check_eq(req, "candidate count", n, exp_n);
        for (int i = 0; i < exp_n && i < n; i++) begin
            check_eq(req, "candidate position", got_pos[(last_base + i) % 64], exp_pos[i]);
            check_eq(req, "candidate index", got_idx[(last_base + i) % 64], exp_idx[i]);
        end
        repeat (3) @(negedge clk);
        check_eq("R10", "done held", int'(done), 1);
        check_eq("R10", "in_ready after done", int'(in_ready), 0);
        check_eq("R10", "cand_valid after done", int'(cand_valid), 0);
    endtask

    task automatic run_case(input string req);
        do_reset();
        load_dut();
        run_stream(req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            $display("FAIL watchdog: actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks + col_checks + 1, errors + col_errors + 1);
            $finish;
        end
    end

    initial begin
        // R11 reset state and empty tables
        do_reset();
        check_eq("R11", "in_ready after reset", int'(in_ready), 1);
        check_eq("R11", "cand_valid after reset", int'(cand_valid), 0);
        check_eq("R11", "done after reset", int'(done), 0);
        clear_tables();
        set_stream(64'h11AB22, 3);
        run_stream("R11");
        check_eq("R11", "no candidates with empty tables", got_n - last_base, 0);

        // R4 R7: confirm entry with zero care still checks the top byte
        clear_tables();
        put(0, 0, 1'b0, 32'hAB00_0000, 32'h0, 2'd0);
        set_stream(64'h11AB22ABAB33, 6);
        run_case("R4");
        check_eq("R7", "forced top-byte compare count", got_n - last_base, 3);
        check_eq("R4", "first candidate position", got_pos[last_base % 64], 1);

        // R1 R2 R3: skip with count 2, skip with count 0
        clear_tables();
        put(0, 0, 1'b0, 32'hAB00_0000, 32'hFF00_0000, 2'd0);
        put(1, 2, 1'b1, 32'h00CD_0000, 32'h00FF_0000, 2'd2);
        put(1, 3, 1'b1, 32'h00EE_0000, 32'h00FF_0000, 2'd0);
        set_stream(64'hABCDABABEEAB11AB, 8);
        run_case("R1");
        check_eq("R1", "position 0 skipped", got_pos[last_base % 64], 2);
        check_eq("R2", "zero-count skip falls to confirm", got_pos[(last_base + 1) % 64], 3);
        check_eq("R3", "miss steps one byte", got_n - last_base, 4);

        // R9: bank priority, then entry priority
        clear_tables();
        put(3, 0, 1'b0, 32'hAB00_0000, 32'hFF00_0000, 2'd0);
        put(2, 3, 1'b0, 32'hAB00_0000, 32'hFF00_0000, 2'd0);
        put(2, 1, 1'b0, 32'hAB00_0000, 32'hFF00_0000, 2'd0);
        set_stream(64'hAB, 1);
        run_case("R9");
        check_eq("R9", "lowest bank and entry index", got_idx[last_base % 64], 9);

        // R6: skip entry care above the low 24 bits is ignored
        clear_tables();
        put(0, 1, 1'b1, 32'h5A00_0000, 32'hFF00_0000, 2'd1);
        put(0, 0, 1'b0, 32'hAB00_0000, 32'hFF00_0000, 2'd0);
        set_stream(64'hABABAB, 3);
        run_case("R6");
        check_eq("R6", "skip on every position", got_n - last_base, 0);

        // R8: entry moved between planes
        clear_tables();
        put(2, 0, 1'b1, 32'hAB00_0000, 32'hFF00_0000, 2'd0);
        set_stream(64'hAB11AB, 3);
        run_case("R8");
        check_eq("R8", "skip-plane entry gives no candidate", got_n - last_base, 0);
        put(2, 0, 1'b0, 32'hAB00_0000, 32'hFF00_0000, 2'd0);
        run_case("R8");
        check_eq("R8", "confirm-plane entry gives candidates", got_n - last_base, 2);

        // R5: backpressure on the candidate output
        clear_tables();
        put(0, 0, 1'b0, 32'hAB00_0000, 32'hFF00_0000, 2'd0);
        bp_mode = 1'b1;
        set_stream(64'hABABABAB, 4);
        run_case("R5");
        check_eq("R5", "all candidates delivered under backpressure", got_n - last_base, 4);
        bp_mode = 1'b0;

        // R10: one-byte stream with zero padding, skip past the end
        set_stream(64'hAB, 1);
        run_case("R10");
        check_eq("R10", "single byte candidate position", got_pos[last_base % 64], 0);
        clear_tables();
        put(0, 0, 1'b0, 32'hAB00_0000, 32'hFF00_0000, 2'd0);
        put(1, 0, 1'b1, 32'h00CD_0000, 32'h00FF_0000, 2'd3);
        set_stream(64'hABCD, 2);
        run_case("R10");
        check_eq("R10", "skip past end ends scan", got_n - last_base, 0);

        // R9 sweep: every 8-byte stream over {AB, CD} against the model
        clear_tables();
        put(0, 1, 1'b0, 32'hABCD_0000, 32'hFFFF_0000, 2'd0);
        put(1, 0, 1'b0, 32'hAB00_0000, 32'hFF00_0000, 2'd0);
        put(2, 0, 1'b1, 32'h0000_CDCD, 32'h0000_FFFF, 2'd3);
        put(0, 2, 1'b1, 32'h00AB_0000, 32'h00FF_0000, 2'd1);
        put(3, 3, 1'b1, 32'h0000_00AB, 32'h0000_00FF, 2'd0);
        for (int s = 0; s < 256; s++) begin
            slen = 8;
            for (int i = 0; i < 8; i++) sbuf[i] = s[i] ? 8'hAB : 8'hCD;
            run_case("R9 sweep");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks + col_checks, errors + col_errors);
        $finish;
    end

endmodule